// File: doc/BRIEF.md
# Legacy Handoff SMI Control and Status Register

This block is a single 32-bit control and status register inside a host controller. It notices three legacy-handoff events: a configuration write to the base address register, a configuration write to the command register, and any change of the OS-owned semaphore. Each event sets its own sticky flag, and software clears that flag by writing a 1 to it. Two further bits are read-only copies of the host-system-error and event-interrupt bits in the controller's status register. The register cannot clear these copies; they follow their source.

Five read/write enable bits each gate one of the five status bits. When an enabled status bit is 1, the block raises a single registered system-management-interrupt request. The request stays high until software clears every enabled active cause or turns off its enable. Software uses a plain register port with byte write strobes. The read port always shows the current register contents. The semaphore, the controller status register and the interrupt handler sit outside the block and reach it only as input signals.

Top module: `legacy_smi_csr`

## Requirements
- R1: Bit 31 reads 1 in the cycle after `barWrite` is sampled high. Writing 1 to bit 31 with byte strobe 3 active clears it at the next edge.
- R2: Bit 30 reads 1 in the cycle after `cmdWrite` is sampled high. Writing 1 to bit 30 with byte strobe 3 active clears it.
- R3: Bit 29 sets on every change of `osOwned`, both 0 to 1 and 1 to 0, and stays clear while `osOwned` holds steady. Writing 1 clears it. A semaphore held at 1 through reset does not count as a change.
- R4: When an event and a write-1-to-clear of the same flag land in the same cycle, the flag stays 1.
- R5: Writing 0 to a flag bit leaves it unchanged. A write whose byte strobe for a bit is inactive leaves that bit unchanged.
- R6: Bit 20 shows `hseStatus` as sampled at the previous clock edge. Register writes cannot change it.
- R7: Bit 16 shows `eintStatus` as sampled at the previous clock edge.
- R8: The enable bits are 15, 14, 13, 4 and 0. They are read/write under their byte strobes and pair, in that order, with status bits 31, 30, 29, 20 and 16.
- R9: `smiReq` is high in a cycle exactly when, one cycle earlier, some enable bit and its paired status bit were both 1.
- R10: After reset every bit reads 0 and `smiReq` is 0. Bits 28:21, 19:17, 12:5 and 3:1 always read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Register write request |
| wrStrb | input | 4 | Byte write strobes, bit n covers data bits 8n+7:8n |
| wrData | input | 32 | Write data |
| barWrite | input | 1 | One-cycle pulse: base address register was written |
| cmdWrite | input | 1 | One-cycle pulse: command register was written |
| osOwned | input | 1 | Current OS-owned semaphore value |
| hseStatus | input | 1 | Host-system-error status bit from the controller status register |
| eintStatus | input | 1 | Event-interrupt status bit from the controller status register |
| rdData | output | 32 | Current register contents |
| smiReq | output | 1 | Registered system-management-interrupt request |

## Verification
The bench builds the block with its default 32-bit register and the default bit pairing, so all five enable/status pairs and every reserved range are reachable through the port. Each event source is paired with its enable in turn. This exposes the one-cycle lag of `smiReq` behind the status it reflects, event-versus-clear collisions, partial byte strobes and writes of 0 to flags. Directed steps then check that a semaphore held at 1 through reset raises no false change, while a later fall is still caught.

// File: rtl/legacy_smi_pkg.sv
package legacy_smi_pkg;

  localparam int REG_W   = 32;
  localparam int STRB_W  = REG_W / 8;
  localparam int FLAG_N  = 3;   // sticky event flags
  localparam int PAIR_N  = 5;   // status/enable pairs, flags first

  // Status bit positions; entries 0..FLAG_N-1 are the sticky flags
  // (base address write, command write, semaphore change), then the shadows.
  localparam int STAT_POS [PAIR_N] = '{31, 30, 29, 20, 16};
  // Enable bit that gates each status entry above, same order.
  localparam int EN_POS   [PAIR_N] = '{15, 14, 13, 4, 0};

  localparam int SRC_BAR = 0;
  localparam int SRC_CMD = 1;
  localparam int SRC_OS  = 2;
  localparam int SHD_HSE = 3;
  localparam int SHD_EIN = 4;

  function automatic logic [REG_W-1:0] bitAt(input int pos);
    return {{(REG_W-1){1'b0}}, 1'b1} << pos;
  endfunction

  function automatic logic [REG_W-1:0] flagMaskCalc();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < FLAG_N; i++) m |= bitAt(STAT_POS[i]);
    return m;
  endfunction

  function automatic logic [REG_W-1:0] enMaskCalc();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < PAIR_N; i++) m |= bitAt(EN_POS[i]);
    return m;
  endfunction

  localparam logic [REG_W-1:0] FLAG_MASK = flagMaskCalc();
  localparam logic [REG_W-1:0] EN_MASK   = enMaskCalc();

  // Strobes from the control side to the datapath, all bit-aligned to the register.
  typedef struct packed {
    logic [REG_W-1:0] setVec;   // flag bits to set this cycle
    logic [REG_W-1:0] clrVec;   // flag bits written with 1
    logic [REG_W-1:0] enMask;   // enable bits being written
  } csrStrobe_t;

endpackage

// File: rtl/legacy_smi_ctrl.sv
module legacy_smi_ctrl
  import legacy_smi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [STRB_W-1:0] wrStrb,
  input  logic [REG_W-1:0]  wrData,
  input  logic              barWrite,
  input  logic              cmdWrite,
  input  logic              osOwned,
  output csrStrobe_t        strobe
);

  logic             prevOs;
  logic             osChange;
  logic [REG_W-1:0] byteMask;
  logic [FLAG_N-1:0] evt;

  // The previous semaphore value is captured on every edge, including during
  // reset, so a level held through reset is never seen as a change.
  always_ff @(posedge clk) begin
    prevOs <= osOwned;
  end

  assign osChange = osOwned ^ prevOs;

  always_comb begin
    evt          = '0;
    evt[SRC_BAR] = barWrite;
    evt[SRC_CMD] = cmdWrite;
    evt[SRC_OS]  = osChange;
  end

  genvar b;
  generate
    for (b = 0; b < STRB_W; b++) begin : g_byte
      assign byteMask[b*8 +: 8] = {8{wrEn & wrStrb[b]}};
    end
  endgenerate

  always_comb begin
    strobe.setVec = '0;
    for (int i = 0; i < FLAG_N; i++)
      strobe.setVec |= evt[i] ? bitAt(STAT_POS[i]) : '0;
    strobe.clrVec = byteMask & wrData & FLAG_MASK;
    strobe.enMask = byteMask & EN_MASK;
  end

  // R3: any change of the sampled semaphore raises the set strobe of its flag
  assert_os_change_R3: assert property (@(posedge clk) disable iff (!rstN)
    (osOwned != $past(osOwned)) |-> strobe.setVec[STAT_POS[SRC_OS]]);

  // R3: a steady semaphore raises no set strobe
  assert_os_steady_R3: assert property (@(posedge clk) disable iff (!rstN)
    (osOwned == $past(osOwned)) |-> !strobe.setVec[STAT_POS[SRC_OS]]);

endmodule

// File: rtl/legacy_smi_dp.sv
module legacy_smi_dp
  import legacy_smi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  csrStrobe_t       strobe,
  input  logic [REG_W-1:0] wrData,
  input  logic             hseStatus,
  input  logic             eintStatus,
  output logic [REG_W-1:0] rdData,
  output logic             smiReq
);

  logic [REG_W-1:0] flagReg;
  logic [REG_W-1:0] shadowReg;
  logic [REG_W-1:0] enReg;
  logic [REG_W-1:0] shadowNext;
  logic [REG_W-1:0] statusVec;
  logic [REG_W-1:0] enAligned;
  logic             causeAny;

  always_comb begin
    shadowNext = (hseStatus  ? bitAt(STAT_POS[SHD_HSE]) : '0)
               | (eintStatus ? bitAt(STAT_POS[SHD_EIN]) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagReg   <= '0;
      shadowReg <= '0;
      enReg     <= '0;
      smiReq    <= 1'b0;
    end else begin
      // A set in the same cycle as a clear wins, so no event is lost.
      flagReg   <= (strobe.setVec | (flagReg & ~strobe.clrVec)) & FLAG_MASK;
      shadowReg <= shadowNext;
      enReg     <= (enReg & ~strobe.enMask) | (wrData & strobe.enMask);
      smiReq    <= causeAny;
    end
  end

  // Move each enable onto the position of the status bit it gates.
  always_comb begin
    statusVec = flagReg | shadowReg;
    enAligned = '0;
    for (int k = 0; k < PAIR_N; k++)
      enAligned |= ((enReg & bitAt(EN_POS[k])) != '0) ? bitAt(STAT_POS[k]) : '0;
    causeAny = |(statusVec & enAligned);
  end

  assign rdData = flagReg | shadowReg | enReg;

  genvar f;
  generate
    for (f = 0; f < FLAG_N; f++) begin : g_flagChk
      // R4: a set strobe always leaves the flag set, even with a clear
      assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rstN)
        strobe.setVec[STAT_POS[f]] |=> flagReg[STAT_POS[f]]);
      // R1: a clear without a coincident event empties the flag
      assert_flag_clr_R1: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.clrVec[STAT_POS[f]] && !strobe.setVec[STAT_POS[f]]) |=> !flagReg[STAT_POS[f]]);
      // R5: with neither strobe the flag keeps its value
      assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
        (!strobe.clrVec[STAT_POS[f]] && !strobe.setVec[STAT_POS[f]]) |=> $stable(flagReg[STAT_POS[f]]));
    end
  endgenerate

  // R6: the error shadow follows its source one edge later
  assert_hse_shadow_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (shadowReg[STAT_POS[SHD_HSE]] == $past(hseStatus)));

  // R7: the event-interrupt shadow follows its source one edge later
  assert_eint_shadow_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (shadowReg[STAT_POS[SHD_EIN]] == $past(eintStatus)));

  // R8: enables hold when no enable byte is written
  assert_en_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enMask == '0) |=> $stable(enReg));

endmodule

// File: rtl/legacy_smi_csr.sv
module legacy_smi_csr
  import legacy_smi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [STRB_W-1:0] wrStrb,
  input  logic [REG_W-1:0]  wrData,
  input  logic              barWrite,
  input  logic              cmdWrite,
  input  logic              osOwned,
  input  logic              hseStatus,
  input  logic              eintStatus,
  output logic [REG_W-1:0]  rdData,
  output logic              smiReq
);

  csrStrobe_t strobe;

  legacy_smi_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrStrb   (wrStrb),
    .wrData   (wrData),
    .barWrite (barWrite),
    .cmdWrite (cmdWrite),
    .osOwned  (osOwned),
    .strobe   (strobe)
  );

  legacy_smi_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .hseStatus  (hseStatus),
    .eintStatus (eintStatus),
    .rdData     (rdData),
    .smiReq     (smiReq)
  );

  // Port-level view of the pending cause, rebuilt from the read data.
  logic portCause;
  always_comb begin
    portCause = 1'b0;
    for (int k = 0; k < PAIR_N; k++)
      portCause |= ((rdData & bitAt(STAT_POS[k])) != '0)
                && ((rdData & bitAt(EN_POS[k])) != '0);
  end

  // R9: the request reflects the register contents of the previous cycle
  assert_smi_level_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (smiReq == $past(portCause)));

  // R10: reserved bits never read as 1
  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~(FLAG_MASK | EN_MASK | bitAt(STAT_POS[SHD_HSE]) | bitAt(STAT_POS[SHD_EIN]))) == '0);

endmodule

// File: tb/sim_legacy_smi_csr.sv
module sim_legacy_smi_csr;

  typedef struct packed {
    logic        wr;
    logic [3:0]  strb;
    logic [31:0] data;
    logic        bar;
    logic        cmd;
    logic        os;
    logic        hse;
    logic        eint;
    logic [31:0] expRd;
    logic        expSmi;
  } vec_t;

  localparam int NVEC = 35;
  // fields: wr, strb, data, bar, cmd, os, hse, eint, expected rdData, expected smiReq
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0}, // 0 R1 set
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0}, // 1 R1 sticky
    '{1'b1, 4'b0010, 32'h0000_8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_8000, 1'b0}, // 2 R8 enable 15
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8000_8000, 1'b1}, // 3 R9
    '{1'b1, 4'b1000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_8000, 1'b1}, // 4 R1 clear
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_8000, 1'b0}, // 5 R9 drop
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h4000_8000, 1'b0}, // 6 R2 set
    '{1'b1, 4'b0010, 32'h0000_4000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h4000_4000, 1'b0}, // 7 R8 swap
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h4000_4000, 1'b1}, // 8 R2
    '{1'b1, 4'b1000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h4000_4000, 1'b1}, // 9 R5 write 0
    '{1'b1, 4'b0111, 32'h4000_4000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h4000_4000, 1'b1}, // 10 R5 strobe off
    '{1'b1, 4'b1000, 32'h4000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h4000_4000, 1'b1}, // 11 R4 collision
    '{1'b1, 4'b1000, 32'h4000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_4000, 1'b1}, // 12 R2 clear
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_4000, 1'b0}, // 13 R2
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h2000_4000, 1'b0}, // 14 R3 rise
    '{1'b1, 4'b1000, 32'h2000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_4000, 1'b0}, // 15 R3 steady, clear
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2000_4000, 1'b0}, // 16 R3 fall
    '{1'b1, 4'b0010, 32'h0000_2000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2000_2000, 1'b0}, // 17 R9
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2000_2000, 1'b1}, // 18 R9
    '{1'b1, 4'b0010, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2000_0000, 1'b1}, // 19 R9 disable
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2000_0000, 1'b0}, // 20 R9
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h2010_0000, 1'b0}, // 21 R6
    '{1'b1, 4'b1111, 32'h0010_0011, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h2010_0011, 1'b0}, // 22 R6 write ignored
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h2010_0011, 1'b1}, // 23 R6
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h2000_0011, 1'b1}, // 24 R6 source clear
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h2001_0011, 1'b0}, // 25 R7
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h2001_0011, 1'b1}, // 26 R7
    '{1'b1, 4'b1111, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_E011, 1'b1}, // 27 R10 reserved
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_E011, 1'b0}, // 28 R10
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'hC000_E011, 1'b0}, // 29 R9 two causes
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hC000_E011, 1'b1}, // 30 R9
    '{1'b1, 4'b1000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h4000_E011, 1'b1}, // 31 R9
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h4000_E011, 1'b1}, // 32 R9 one left
    '{1'b1, 4'b1000, 32'h4000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_E011, 1'b1}, // 33 R9
    '{1'b0, 4'b0000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_E011, 1'b0}  // 34 R9 all clear
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [3:0]  wrStrb;
  logic [31:0] wrData;
  logic        barWrite, cmdWrite, osOwned, hseStatus, eintStatus;
  logic [31:0] rdData;
  logic        smiReq;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  legacy_smi_csr u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrStrb(wrStrb), .wrData(wrData),
    .barWrite(barWrite), .cmdWrite(cmdWrite), .osOwned(osOwned),
    .hseStatus(hseStatus), .eintStatus(eintStatus),
    .rdData(rdData), .smiReq(smiReq)
  );

  function automatic string tagFor(input int i);
    if (i <= 1)  return "R1";
    if (i == 2)  return "R8";
    if (i == 3)  return "R9";
    if (i == 4)  return "R1";
    if (i == 5)  return "R9";
    if (i <= 8)  return "R2";
    if (i <= 10) return "R5";
    if (i == 11) return "R4";
    if (i <= 13) return "R2";
    if (i <= 16) return "R3";
    if (i <= 20) return "R9";
    if (i <= 24) return "R6";
    if (i <= 26) return "R7";
    if (i <= 28) return "R10";
    return "R9";
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic idleInputs();
    wrEn = 1'b0; wrStrb = '0; wrData = '0;
    barWrite = 1'b0; cmdWrite = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; osOwned = 1'b0; hseStatus = 1'b0; eintStatus = 1'b0;
    idleInputs();
    repeat (3) @(negedge clk);
    // R10: reset state
    check(rdData == 32'h0, "R10 reset rdData", rdData, 32'h0);
    check(smiReq == 1'b0, "R10 reset smiReq", {31'h0, smiReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      wrEn = VECS[i].wr; wrStrb = VECS[i].strb; wrData = VECS[i].data;
      barWrite = VECS[i].bar; cmdWrite = VECS[i].cmd; osOwned = VECS[i].os;
      hseStatus = VECS[i].hse; eintStatus = VECS[i].eint;
      @(negedge clk);
      check(rdData == VECS[i].expRd,
            $sformatf("%s vector %0d rdData", tagFor(i), i), rdData, VECS[i].expRd);
      check(smiReq == VECS[i].expSmi,
            $sformatf("%s vector %0d smiReq", tagFor(i), i), {31'h0, smiReq}, {31'h0, VECS[i].expSmi});
    end

    // R10 / R3: semaphore held at 1 through reset, with a pending event
    idleInputs();
    osOwned = 1'b1; barWrite = 1'b1; rstN = 1'b0;
    repeat (3) @(negedge clk);
    barWrite = 1'b0; rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(rdData == 32'h0, "R10 rdData after mid-run reset", rdData, 32'h0);
    check(smiReq == 1'b0, "R10 smiReq after mid-run reset", {31'h0, smiReq}, 32'h0);
    check(rdData == 32'h0, "R3 no change seen for level held through reset", rdData, 32'h0);

    // R3: fall after reset is still detected
    osOwned = 1'b0;
    @(negedge clk);
    check(rdData == 32'h2000_0000, "R3 fall after reset", rdData, 32'h2000_0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule